// File: doc/BRIEF.md
# General Register File With Address Pointer Pairs

This block holds the working registers of an 8-bit processor core: thirty-two byte-wide entries with two combinational byte read ports, one combinational 16-bit pair read, and a single write port that stores either one byte or an aligned pair of bytes. A pair is always an even register (low byte) together with the odd register above it (high byte). The pair index is the register number with bit 0 dropped.

The six highest registers double as three 16-bit address pointers. Pointer 0 is registers 26/27, pointer 1 is 28/29 and pointer 2 is 30/31, each with the low byte in the even register. All three are driven continuously on a dedicated output bus. A parameter picks one of them as the lookup-table address for program-memory reads. A one-cycle pointer command either post-increments or pre-decrements the selected pointer in place. It presents the address for the memory access on its own output during that same cycle. Decode, the ALU and memory sit outside the block and drive its ports.

Top module: `gpr_file`

## Requirements
- R1: While rst_ni is low, and after it rises until the first write, every register reads 0x00 and every pointer output is 0x0000.
- R2: rd_a_o and rd_b_o show, in the same cycle and independently, the registers numbered by rd_a_idx_i and rd_b_idx_i.
- R3: With wr_en_i=1 and wr_wide_i=0, register wr_idx_i takes wr_data_i[7:0] at the clock edge, and no other register changes.
- R4: With wr_en_i=1 and wr_wide_i=1, the even register of the pair wr_idx_i[4:1] takes wr_data_i[7:0] and the odd one takes wr_data_i[15:8]; wr_idx_i[0] has no effect.
- R5: rd_pair_o is {register 2k+1, register 2k} with k = rd_a_idx_i[4:1]; rd_a_idx_i[0] does not affect it.
- R6: ptrs_o[15:0], [31:16] and [47:32] carry {r27,r26}, {r29,r28} and {r31,r30}; lut_addr_o equals the pointer numbered by parameter LUT_PTR (default 2).
- R7: ptr_cmd_i encodes 2'b00 no-op, 2'b01 post-increment, 2'b10 pre-decrement, 2'b11 no-op; ptr_sel_i 0..2 selects a pointer and 3 makes any command a no-op with ptr_addr_o = 0x0000. A no-op leaves every register unchanged. For a no-op or post-increment, ptr_addr_o is the selected pointer's current value. A post-increment stores that value plus one (modulo 2^16) at the edge.
- R8: For a pre-decrement, ptr_addr_o is the selected pointer minus one (modulo 2^16) in that cycle, and the pointer holds that value after the edge.
- R9: A read of a register written in the same cycle returns the contents from before the write; the new value appears after the edge.
- R10: When a port write and a pointer update touch the same pointer in one cycle, each byte written by the port takes the port data. Any byte of that pointer not written by the port takes the updated pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 5 | Register number for read port A and pair read |
| rd_b_idx_i | input | 5 | Register number for read port B |
| rd_a_o | output | 8 | Byte read on port A |
| rd_b_o | output | 8 | Byte read on port B |
| rd_pair_o | output | 16 | Pair selected by rd_a_idx_i[4:1] |
| wr_en_i | input | 1 | Write enable |
| wr_wide_i | input | 1 | 1 = pair write, 0 = byte write |
| wr_idx_i | input | 5 | Destination register number |
| wr_data_i | input | 16 | Write data (high byte used by pair writes) |
| ptr_cmd_i | input | 2 | Pointer command |
| ptr_sel_i | input | 2 | Pointer number for the command |
| ptr_addr_o | output | 16 | Address produced by the pointer command |
| ptrs_o | output | 48 | All three pointers, pointer 0 in the low bits |
| lut_addr_o | output | 16 | Pointer used for program-memory table reads |

## Verification
The bench builds the block with its defaults: 8-bit registers, 32 entries, three pointers and pointer 2 as the table address. With these sizes it can sweep every register through both read ports and every pair through the pair read. It can also drive the 16-bit pointers to 0xFFFF and 0x0000, so both wrap directions are tested. The same setup covers a write colliding with an increment on the top pointer's low byte, a read of a register in the cycle it is written, and both kinds of ignored command.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    PTR_NOP     = 2'b00,
    PTR_POSTINC = 2'b01,
    PTR_PREDEC  = 2'b10,
    PTR_RSVD    = 2'b11
  } ptr_cmd_e;
endpackage

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int DW    = 8,
  parameter int NREGS = 32,
  parameter int LANES = 1,
  localparam int AW   = $clog2(NREGS),
  localparam int SH   = (LANES > 1) ? 1 : 0,
  localparam int IW   = AW - SH
) (
  input  logic [NREGS-1:0][DW-1:0] regs_i,
  input  logic [IW-1:0]            idx_i,
  output logic [LANES*DW-1:0]      data_o
);
  logic [AW-1:0] base;
  assign base = AW'(idx_i) << SH;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign data_o[l*DW +: DW] = regs_i[base + AW'(l)];
  end
endmodule

// File: rtl/gpr_ptr_unit.sv
module gpr_ptr_unit #(
  parameter int DW   = 8,
  parameter int NPTR = 3,
  localparam int PW  = 2 * DW,
  localparam int PSW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic [NPTR-1:0][PW-1:0] ptrs_i,
  input  logic [1:0]              cmd_i,
  input  logic [PSW-1:0]          sel_i,
  output logic [NPTR-1:0]         upd_o,
  output logic [PW-1:0]           next_o,
  output logic [PW-1:0]           addr_o
);
  import gpr_pkg::*;

  ptr_cmd_e    cmd;
  logic        valid;
  logic        act;
  logic [PW-1:0] cur;

  assign cmd = ptr_cmd_e'(cmd_i);

  always_comb begin
    valid = 1'b0;
    cur   = '0;
    for (int p = 0; p < NPTR; p++) begin
      if (sel_i == PSW'(p)) begin
        valid = 1'b1;
        cur   = ptrs_i[p];
      end
    end
  end

  always_comb begin
    act    = 1'b0;
    next_o = cur;
    addr_o = cur;
    unique case (cmd)
      PTR_POSTINC: begin
        act    = valid;
        next_o = cur + PW'(1);
      end
      PTR_PREDEC: begin
        act    = valid;
        next_o = cur - PW'(1);
        addr_o = cur - PW'(1);
      end
      default: ;
    endcase
    if (!valid) addr_o = '0;
  end

  always_comb begin
    for (int p = 0; p < NPTR; p++) upd_o[p] = act && (sel_i == PSW'(p));
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int DW    = 8,
  parameter int NREGS = 32,
  parameter int NPTR  = 3,
  localparam int AW   = $clog2(NREGS),
  localparam int PW   = 2 * DW,
  localparam int PTR_BASE = NREGS - 2 * NPTR
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic                     wr_wide_i,
  input  logic [AW-1:0]            wr_idx_i,
  input  logic [PW-1:0]            wr_data_i,
  input  logic [NPTR-1:0]          ptr_upd_i,
  input  logic [PW-1:0]            ptr_next_i,
  output logic [NREGS-1:0][DW-1:0] regs_o
);
  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    logic          wr_hit;
    logic [DW-1:0] wr_val;
    logic          ptr_hit;
    logic [DW-1:0] ptr_val;

    assign wr_hit = wr_en_i &&
                    (wr_wide_i ? (wr_idx_i[AW-1:1] == (AW-1)'(r / 2))
                               : (wr_idx_i == AW'(r)));

    if ((r % 2) == 1) begin : g_odd
      assign wr_val = wr_wide_i ? wr_data_i[PW-1:DW] : wr_data_i[DW-1:0];
    end else begin : g_even
      assign wr_val = wr_data_i[DW-1:0];
    end

    if (r >= PTR_BASE) begin : g_ptr
      assign ptr_hit = ptr_upd_i[(r - PTR_BASE) / 2];
      assign ptr_val = ptr_next_i[(r % 2) * DW +: DW];
    end else begin : g_plain
      assign ptr_hit = 1'b0;
      assign ptr_val = '0;
    end

    // port write has priority over pointer update
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      regs_o[r] <= '0;
      else if (wr_hit)  regs_o[r] <= wr_val;
      else if (ptr_hit) regs_o[r] <= ptr_val;
    end
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file #(
  parameter int DW      = 8,
  parameter int NREGS   = 32,
  parameter int NPTR    = 3,
  parameter int LUT_PTR = 2,
  localparam int AW     = $clog2(NREGS),
  localparam int PW     = 2 * DW,
  localparam int PSW    = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int PTR_BASE = NREGS - 2 * NPTR
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      rd_a_idx_i,
  input  logic [AW-1:0]      rd_b_idx_i,
  output logic [DW-1:0]      rd_a_o,
  output logic [DW-1:0]      rd_b_o,
  output logic [PW-1:0]      rd_pair_o,
  input  logic               wr_en_i,
  input  logic               wr_wide_i,
  input  logic [AW-1:0]      wr_idx_i,
  input  logic [PW-1:0]      wr_data_i,
  input  logic [1:0]         ptr_cmd_i,
  input  logic [PSW-1:0]     ptr_sel_i,
  output logic [PW-1:0]      ptr_addr_o,
  output logic [NPTR*PW-1:0] ptrs_o,
  output logic [PW-1:0]      lut_addr_o
);
  import gpr_pkg::*;

  logic [NREGS-1:0][DW-1:0] regs;
  logic [NPTR-1:0][PW-1:0]  ptrs;
  logic [NPTR-1:0]          ptr_upd;
  logic [PW-1:0]            ptr_next;

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    assign ptrs[p] = {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
    assign ptrs_o[p*PW +: PW] = ptrs[p];
  end
  assign lut_addr_o = ptrs[LUT_PTR];

  gpr_bank #(.DW(DW), .NREGS(NREGS), .NPTR(NPTR)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_wide_i  (wr_wide_i),
    .wr_idx_i   (wr_idx_i),
    .wr_data_i  (wr_data_i),
    .ptr_upd_i  (ptr_upd),
    .ptr_next_i (ptr_next),
    .regs_o     (regs)
  );

  gpr_ptr_unit #(.DW(DW), .NPTR(NPTR)) u_ptr (
    .ptrs_i (ptrs),
    .cmd_i  (ptr_cmd_i),
    .sel_i  (ptr_sel_i),
    .upd_o  (ptr_upd),
    .next_o (ptr_next),
    .addr_o (ptr_addr_o)
  );

  gpr_read_port #(.DW(DW), .NREGS(NREGS), .LANES(1)) u_rd_a (
    .regs_i (regs), .idx_i (rd_a_idx_i), .data_o (rd_a_o)
  );

  gpr_read_port #(.DW(DW), .NREGS(NREGS), .LANES(1)) u_rd_b (
    .regs_i (regs), .idx_i (rd_b_idx_i), .data_o (rd_b_o)
  );

  gpr_read_port #(.DW(DW), .NREGS(NREGS), .LANES(2)) u_rd_pair (
    .regs_i (regs), .idx_i (rd_a_idx_i[AW-1:1]), .data_o (rd_pair_o)
  );

  logic sel_ok;
  assign sel_ok = int'(ptr_sel_i) < NPTR;

  AST_WR_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_wide_i |=> regs[$past(wr_idx_i)] == $past(wr_data_i[DW-1:0])); // R3

  AST_WR_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_wide_i |=>
      {regs[{$past(wr_idx_i[AW-1:1]), 1'b1}], regs[{$past(wr_idx_i[AW-1:1]), 1'b0}]}
        == $past(wr_data_i)); // R4

  AST_PTR_POSTINC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && sel_ok && ptr_cmd_i == PTR_POSTINC |=>
      ptrs[$past(ptr_sel_i)] == $past(ptr_addr_o) + PW'(1)); // R7

  AST_PTR_PREDEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && sel_ok && ptr_cmd_i == PTR_PREDEC |=>
      ptrs[$past(ptr_sel_i)] == $past(ptr_addr_o)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && (!sel_ok || ptr_cmd_i == PTR_NOP || ptr_cmd_i == PTR_RSVD) |=>
      $stable(regs)); // R7
endmodule

// File: tb/gpr_file_tb.sv
`timescale 1ns/1ps
module gpr_file_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
  logic [7:0]  rd_a_o, rd_b_o;
  logic [15:0] rd_pair_o, wr_data_i = '0, ptr_addr_o, lut_addr_o;
  logic        wr_en_i = 1'b0, wr_wide_i = 1'b0;
  logic [1:0]  ptr_cmd_i = '0, ptr_sel_i = '0;
  logic [47:0] ptrs_o;

  int checks = 0;
  int failures = 0;
  logic [7:0] m [32];

  always #4 clk_i = ~clk_i;

  gpr_file u_dut (
    .clk_i, .rst_ni, .rd_a_idx_i, .rd_b_idx_i, .rd_a_o, .rd_b_o, .rd_pair_o,
    .wr_en_i, .wr_wide_i, .wr_idx_i, .wr_data_i, .ptr_cmd_i, .ptr_sel_i,
    .ptr_addr_o, .ptrs_o, .lut_addr_o
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mptr(int p);
    return {m[27 + 2*p], m[26 + 2*p]};
  endfunction

  task automatic check_all(string req);
    for (int i = 0; i < 32; i++) begin
      rd_a_idx_i = 5'(i);
      rd_b_idx_i = 5'(31 - i);
      #0.25;
      chk(req, {8'h0, rd_a_o}, {8'h0, m[i]});
      chk(req, {8'h0, rd_b_o}, {8'h0, m[31 - i]});
    end
    for (int p = 0; p < 3; p++) chk({req, "/R6 ptr"}, ptrs_o[p*16 +: 16], mptr(p));
    chk({req, "/R6 lut"}, lut_addr_o, mptr(2));
  endtask

  task automatic wr_op(int idx, logic [15:0] d, logic wide);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_wide_i = wide; wr_idx_i = 5'(idx); wr_data_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; wr_wide_i = 1'b0;
    if (wide) begin
      m[idx & 30] = d[7:0];
      m[idx | 1]  = d[15:8];
    end else m[idx] = d[7:0];
  endtask

  task automatic ptr_op(string req, logic [1:0] cmd, logic [1:0] sel, logic [15:0] exp_addr);
    @(negedge clk_i);
    ptr_cmd_i = cmd; ptr_sel_i = sel;
    #1 chk({req, " addr"}, ptr_addr_o, exp_addr);
    @(posedge clk_i); #1;
    ptr_cmd_i = 2'b00; ptr_sel_i = 2'b00;
  endtask

  task automatic t_reset();
    #1 chk("R1 ptrs in reset", ptrs_o[15:0] | ptrs_o[31:16] | ptrs_o[47:32], 16'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    check_all("R1 reset");
  endtask

  task automatic t_byte_write();
    wr_op(0, 16'hFFA5, 1'b0);
    wr_op(31, 16'h003C, 1'b0);
    wr_op(7, 16'h1181, 1'b0);
    wr_op(16, 16'h00FF, 1'b0);
    wr_op(13, 16'h0042, 1'b0);
    check_all("R3/R2 byte write");
  endtask

  task automatic t_pair_write();
    wr_op(5, 16'hBEEF, 1'b1);   // odd index: bit 0 ignored
    wr_op(10, 16'h1234, 1'b1);
    wr_op(20, 16'hC0DE, 1'b1);
    check_all("R4 pair write");
  endtask

  task automatic t_pair_read();
    for (int k = 0; k < 16; k++) begin
      for (int b = 0; b < 2; b++) begin
        rd_a_idx_i = 5'(2*k + b);
        #0.25 chk("R5 pair read", rd_pair_o, {m[2*k + 1], m[2*k]});
      end
    end
  endtask

  task automatic t_ptr_outputs();
    wr_op(26, 16'h0102, 1'b1);
    wr_op(29, 16'h0304, 1'b1);
    wr_op(30, 16'hFFFF, 1'b1);
    check_all("R6 pointer map");
    chk("R6 X", ptrs_o[15:0], 16'h0102);
    chk("R6 Y", ptrs_o[31:16], 16'h0304);
    chk("R6 lut", lut_addr_o, 16'hFFFF);
  endtask

  task automatic t_postinc();
    ptr_op("R7 postinc wrap", 2'b01, 2'd2, 16'hFFFF);
    m[30] = 8'h00; m[31] = 8'h00;
    chk("R7 postinc wrap", ptrs_o[47:32], 16'h0000);
    ptr_op("R7 postinc X", 2'b01, 2'd0, 16'h0102);
    m[26] = 8'h03;
    chk("R7 postinc X", ptrs_o[15:0], 16'h0103);
    check_all("R7 postinc others");
  endtask

  task automatic t_predec();
    ptr_op("R8 predec wrap", 2'b10, 2'd2, 16'hFFFF);
    m[30] = 8'hFF; m[31] = 8'hFF;
    chk("R8 predec wrap", ptrs_o[47:32], 16'hFFFF);
    ptr_op("R8 predec Y", 2'b10, 2'd1, 16'h0303);
    m[28] = 8'h03;
    chk("R8 predec Y", ptrs_o[31:16], 16'h0303);
    check_all("R8 predec others");
  endtask

  task automatic t_ignored();
    ptr_op("R7 reserved cmd", 2'b11, 2'd0, 16'h0103);
    ptr_op("R7 invalid sel inc", 2'b01, 2'd3, 16'h0000);
    ptr_op("R7 invalid sel dec", 2'b10, 2'd3, 16'h0000);
    ptr_op("R7 nop Y", 2'b00, 2'd1, 16'h0303);
    check_all("R7 ignored commands");
  endtask

  task automatic t_read_old();
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_wide_i = 1'b0; wr_idx_i = 5'd3; wr_data_i = 16'h0077;
    rd_a_idx_i = 5'd3; rd_b_idx_i = 5'd3;
    #1;
    chk("R9 old A", {8'h0, rd_a_o}, {8'h0, m[3]});
    chk("R9 old B", {8'h0, rd_b_o}, {8'h0, m[3]});
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; m[3] = 8'h77;
    chk("R9 new A", {8'h0, rd_a_o}, 16'h0077);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_wide_i = 1'b1; wr_idx_i = 5'd10; wr_data_i = 16'hA55A;
    rd_a_idx_i = 5'd10;
    #1 chk("R9 old pair", rd_pair_o, {m[11], m[10]});
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; wr_wide_i = 1'b0; m[10] = 8'h5A; m[11] = 8'hA5;
    chk("R9 new pair", rd_pair_o, 16'hA55A);
  endtask

  task automatic t_collision();
    // Z = 0xFFFF; increment gives 0x0000, low byte overwritten by port
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_wide_i = 1'b0; wr_idx_i = 5'd30; wr_data_i = 16'h0040;
    ptr_cmd_i = 2'b01; ptr_sel_i = 2'd2;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; ptr_cmd_i = 2'b00; ptr_sel_i = 2'd0;
    m[30] = 8'h40; m[31] = 8'h00;
    chk("R10 collision", ptrs_o[47:32], 16'h0040);
    check_all("R10 collision others");
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3;
    t_reset();
    t_byte_write();
    t_pair_write();
    t_pair_read();
    t_ptr_outputs();
    t_postinc();
    t_predec();
    t_ignored();
    t_read_old();
    t_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule